// File: doc/BRIEF.md
# Multi-Digit Decimal Carry-Lookahead Adder

The block adds two unsigned decimal numbers held as packed 8421 BCD, four bits per digit, with a one-bit carry-in. It returns a BCD sum of the same digit count and a carry-out that signals a result of ten to the power of the digit count or more. The digit count `DIGITS` is a parameter and must be a multiple of four.

Each digit position works out from its two operand digits alone whether it will always send a carry onward (pair sum of ten or more) or will only pass on an incoming one (pair sum of exactly nine). Four neighbouring digits are folded into one group with its own generate and propagate terms. A second lookahead level works out the carry into every group straight from the carry-in and the group terms. Each digit then forms its binary sum with its own carry, and a sum above nine is corrected by adding six modulo sixteen.

By default the sum and carry-out are captured in an output register that is cleared by an active-low reset. With `OUT_REG` set to 0 the block is purely combinational.

Top module: `bcdla_adder`

## Requirements
- R1: With `OUT_REG`=1, the sum digits equal the D least significant decimal digits of A + B + carry-in. Digit i occupies bits 4i+3..4i, and digit 0 is least significant.
- R2: The carry-out is 1 exactly when A + B + carry-in is at least 10^D.
- R3: For operands whose digits are all 0 to 9, every sum digit is in the range 0 to 9.
- R4: Digit correction handles every digit-pair total above nine. This covers totals of 10 to 15, which are unused codes, and totals of 16 to 19, which overflow four bits. For example, 8+8 gives digit 6 with a carry and 7+8 gives digit 5 with a carry.
- R5: An incoming carry ripples through any run of digit pairs that sum to nine. With A all nines, B zero and carry-in 1, the sum is all zeros and the carry-out is 1.
- R6: A carry generated inside one four-digit group reaches the next groups through groups that only propagate.
- R7: The carry-in adds exactly one at the least significant digit. With B zero and carry-in 0, the sum equals A and the carry-out is 0.
- R8: With `OUT_REG`=1, the result of inputs applied before a rising clock edge appears after that edge and not before it. While `rst_n` is low, the sum and carry-out are zero.
- R9: When the two most significant operand digits sum to eight or less, the carry-out is 0 whatever the carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous clear of the output register |
| a_i | input | 4*DIGITS | Operand A, packed BCD |
| b_i | input | 4*DIGITS | Operand B, packed BCD |
| cin_i | input | 1 | Carry-in |
| sum_o | output | 4*DIGITS | Sum, packed BCD |
| cout_o | output | 1 | Decimal carry-out |

## Verification
Operands of all nines with a carry-in, and digit runs of nine that end in a generating digit, separate a correct lookahead from one that drops propagation, whether inside a group or across group boundaries. Pairs of eights and of seven with eight separate the two ranges of decimal correction. Operands that are zero apart from the carry-in show how the carry-in is weighted. Random valid operands, checked against an integer-based decimal model, cover mixed generate and propagate patterns. A top digit total of eight marks the point below which no carry may leave the adder.

// File: rtl/bcdla_pkg.sv
package bcdla_pkg;
    localparam int DIG_W   = 4;
    localparam int GRP_DIG = 4;
    typedef logic [DIG_W-1:0] bcd_digit_t;
endpackage

// File: rtl/bcdla_digit_pg.sv
module bcdla_digit_pg
    import bcdla_pkg::*;
(
    input  bcd_digit_t a_i,
    input  bcd_digit_t b_i,
    output logic       gen_o,
    output logic       prop_o
);
    logic [DIG_W:0] pair_sum;

    always_comb begin
        pair_sum = {1'b0, a_i} + {1'b0, b_i};
        gen_o    = (pair_sum >= 5'd10);
        prop_o   = (pair_sum == 5'd9);
    end
endmodule

// File: rtl/bcdla_digit_sum.sv
module bcdla_digit_sum
    import bcdla_pkg::*;
(
    input  bcd_digit_t a_i,
    input  bcd_digit_t b_i,
    input  logic       cin_i,
    output bcd_digit_t sum_o
);
    logic [DIG_W:0] bin_sum;

    always_comb begin
        bin_sum = {1'b0, a_i} + {1'b0, b_i} + {{DIG_W{1'b0}}, cin_i};
        if (bin_sum > 5'd9) begin
            sum_o = bin_sum[DIG_W-1:0] + 4'd6;
        end else begin
            sum_o = bin_sum[DIG_W-1:0];
        end
    end
endmodule

// File: rtl/bcdla_group.sv
module bcdla_group #(
    parameter int GD = 4
) (
    input  logic [GD-1:0] gen_i,
    input  logic [GD-1:0] prop_i,
    input  logic          cin_i,
    output logic [GD-1:0] dcarry_o,
    output logic          grp_gen_o,
    output logic          grp_prop_o
);
    always_comb begin
        for (int i = 0; i < GD; i++) begin
            logic term_all;
            logic acc;
            term_all = cin_i;
            acc      = 1'b0;
            for (int k = 0; k < i; k++) begin
                logic path;
                path = gen_i[k];
                for (int m = k + 1; m < i; m++) begin
                    path = path & prop_i[m];
                end
                acc      = acc | path;
                term_all = term_all & prop_i[k];
            end
            dcarry_o[i] = acc | term_all;
        end
    end

    always_comb begin
        grp_prop_o = &prop_i;
        grp_gen_o  = 1'b0;
        for (int k = 0; k < GD; k++) begin
            logic path;
            path = gen_i[k];
            for (int m = k + 1; m < GD; m++) begin
                path = path & prop_i[m];
            end
            grp_gen_o = grp_gen_o | path;
        end
    end
endmodule

// File: rtl/bcdla_adder.sv
module bcdla_adder
    import bcdla_pkg::*;
#(
    parameter int DIGITS  = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DIGITS*4-1:0]   a_i,
    input  logic [DIGITS*4-1:0]   b_i,
    input  logic                  cin_i,
    output logic [DIGITS*4-1:0]   sum_o,
    output logic                  cout_o
);
    localparam int WIDTH  = DIGITS * DIG_W;
    localparam int GROUPS = DIGITS / GRP_DIG;

    logic [DIGITS-1:0] dig_gen;
    logic [DIGITS-1:0] dig_prop;
    logic [DIGITS-1:0] dig_cin;
    logic [GROUPS-1:0] grp_gen;
    logic [GROUPS-1:0] grp_prop;
    logic [GROUPS-1:0] grp_cin;
    logic [WIDTH-1:0]  sum_comb;
    logic              cout_comb;

    for (genvar d = 0; d < DIGITS; d++) begin : g_pg
        bcdla_digit_pg u_pg (
            .a_i    (a_i[d*DIG_W +: DIG_W]),
            .b_i    (b_i[d*DIG_W +: DIG_W]),
            .gen_o  (dig_gen[d]),
            .prop_o (dig_prop[d])
        );
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        bcdla_group #(.GD(GRP_DIG)) u_grp (
            .gen_i      (dig_gen[g*GRP_DIG +: GRP_DIG]),
            .prop_i     (dig_prop[g*GRP_DIG +: GRP_DIG]),
            .cin_i      (grp_cin[g]),
            .dcarry_o   (dig_cin[g*GRP_DIG +: GRP_DIG]),
            .grp_gen_o  (grp_gen[g]),
            .grp_prop_o (grp_prop[g])
        );
    end

    // second lookahead level: each group carry from cin and group terms
    always_comb begin
        for (int j = 0; j < GROUPS; j++) begin
            logic all_p;
            logic acc;
            all_p = cin_i;
            acc   = 1'b0;
            for (int k = 0; k < j; k++) begin
                logic path;
                path = grp_gen[k];
                for (int m = k + 1; m < j; m++) begin
                    path = path & grp_prop[m];
                end
                acc   = acc | path;
                all_p = all_p & grp_prop[k];
            end
            grp_cin[j] = acc | all_p;
        end
        cout_comb = grp_gen[GROUPS-1] | (grp_prop[GROUPS-1] & grp_cin[GROUPS-1]);
    end

    for (genvar d = 0; d < DIGITS; d++) begin : g_sum
        bcdla_digit_sum u_sum (
            .a_i   (a_i[d*DIG_W +: DIG_W]),
            .b_i   (b_i[d*DIG_W +: DIG_W]),
            .cin_i (dig_cin[d]),
            .sum_o (sum_comb[d*DIG_W +: DIG_W])
        );
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sum_o  <= '0;
                cout_o <= 1'b0;
            end else begin
                sum_o  <= sum_comb;
                cout_o <= cout_comb;
            end
        end
    end else begin : g_comb
        assign sum_o  = sum_comb;
        assign cout_o = cout_comb;
    end
endmodule

// File: rtl/bcdla_checker.sv
module bcdla_checker #(
    parameter int DIGITS  = 16,
    parameter bit OUT_REG = 1'b1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [DIGITS*4-1:0] a_i,
    input logic [DIGITS*4-1:0] b_i,
    input logic                cin_i,
    input logic [DIGITS*4-1:0] sum_o,
    input logic                cout_o
);
    localparam int W = DIGITS * 4;
    localparam logic [W-1:0] NINES = {DIGITS{4'h9}};

    logic [W-1:0] al_a;
    logic [W-1:0] al_b;
    logic         al_cin;

    if (OUT_REG) begin : g_align
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                al_a   <= '0;
                al_b   <= '0;
                al_cin <= 1'b0;
            end else begin
                al_a   <= a_i;
                al_b   <= b_i;
                al_cin <= cin_i;
            end
        end
    end else begin : g_direct
        assign al_a   = a_i;
        assign al_b   = b_i;
        assign al_cin = cin_i;
    end

    logic       all_valid;
    logic [4:0] low_raw;
    logic [3:0] low_exp;
    logic [4:0] top_pair;

    always_comb begin
        all_valid = 1'b1;
        for (int d = 0; d < DIGITS; d++) begin
            if (sum_o[d*4 +: 4] > 4'd9) all_valid = 1'b0;
        end
        low_raw  = {1'b0, al_a[3:0]} + {1'b0, al_b[3:0]} + {4'd0, al_cin};
        low_exp  = (low_raw >= 5'd10) ? 4'(low_raw - 5'd10) : low_raw[3:0];
        top_pair = {1'b0, al_a[W-1 -: 4]} + {1'b0, al_b[W-1 -: 4]};
    end

    AST_DIGITS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        all_valid); // R3

    AST_LOW_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
        (al_a[3:0] <= 4'd9 && al_b[3:0] <= 4'd9) |-> (sum_o[3:0] == low_exp)); // R1

    AST_NINES_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (al_a == NINES && al_b == '0) |->
            (cout_o == al_cin && sum_o == (al_cin ? '0 : NINES))); // R5

    AST_ZERO_CIN: assert property (@(posedge clk) disable iff (!rst_n)
        (al_b == '0 && !al_cin) |-> (sum_o == al_a && !cout_o)); // R7

    AST_NO_TOP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (top_pair <= 5'd8) |-> !cout_o); // R9
endmodule

bind bcdla_adder bcdla_checker #(.DIGITS(DIGITS), .OUT_REG(OUT_REG)) u_bcdla_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o)
);

// File: tb/bcdla_adder_bench.sv
`timescale 1ns/1ps
module bcdla_adder_bench;
    localparam int D = 16;
    localparam int W = D * 4;
    localparam longint unsigned LIMIT = 64'd10000000000000000;

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         cin;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b0}, // R1 zero
        '{64'h9999_9999_9999_9999, 64'h0000_0000_0000_0000, 1'b1}, // R5 full chain
        '{64'h9999_9999_9999_9999, 64'h9999_9999_9999_9999, 1'b1}, // R2 max
        '{64'h8888_8888_8888_8888, 64'h8888_8888_8888_8888, 1'b0}, // R4 16 per digit
        '{64'h0000_0000_0000_0009, 64'h0000_0000_0000_0001, 1'b0}, // R4 exactly 10
        '{64'h0000_0000_9999_9995, 64'h0000_0000_0000_0005, 1'b0}, // R6 group cross
        '{64'h4999_9999_9999_9999, 64'h0000_0000_0000_0000, 1'b1}, // R5 stop at top
        '{64'h1234_5678_9012_3456, 64'h8765_4321_0987_6543, 1'b0}, // R1 no carries
        '{64'h5000_0000_0000_0000, 64'h5000_0000_0000_0000, 1'b0}, // R2 top carry
        '{64'h4000_0000_0000_0000, 64'h4999_9999_9999_9999, 1'b1}, // R9 top pair 8
        '{64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b1}, // R7 cin weight
        '{64'h0000_0000_0000_0007, 64'h0000_0000_0000_0008, 1'b0}  // R4 15 per digit
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         cin_i = 1'b0;
    logic [W-1:0] sum_o;
    logic         cout_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bcdla_adder #(.DIGITS(D), .OUT_REG(1'b1)) u_bcdla_adder (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (cin_i),
        .sum_o  (sum_o),
        .cout_o (cout_o)
    );

    function automatic longint unsigned to_int(input logic [W-1:0] v);
        longint unsigned r = 0;
        for (int d = D - 1; d >= 0; d--) r = r * 10 + longint'(v[d*4 +: 4]);
        return r;
    endfunction

    function automatic logic [W-1:0] to_bcd(input longint unsigned v);
        logic [W-1:0] r = '0;
        longint unsigned t = v;
        for (int d = 0; d < D; d++) begin
            r[d*4 +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic expect_eq(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_vec(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
        longint unsigned tot;
        logic [W-1:0] esum;
        logic ecout;
        logic okdig;
        tot   = to_int(a) + to_int(b) + longint'(c);
        ecout = (tot >= LIMIT);
        esum  = to_bcd(ecout ? tot - LIMIT : tot);
        @(negedge clk);
        a_i = a; b_i = b; cin_i = c;
        @(negedge clk);
        expect_eq("R1 sum", sum_o, esum);
        expect_eq("R2 carry-out", {{(W-1){1'b0}}, cout_o}, {{(W-1){1'b0}}, ecout});
        okdig = 1'b1;
        for (int d = 0; d < D; d++) if (sum_o[d*4 +: 4] > 4'd9) okdig = 1'b0;
        expect_eq("R3 digit range", {{(W-1){1'b0}}, okdig}, {{(W-1){1'b0}}, 1'b1});
    endtask

    function automatic logic [W-1:0] rand_bcd();
        logic [W-1:0] r;
        for (int d = 0; d < D; d++) r[d*4 +: 4] = 4'($urandom_range(0, 9));
        return r;
    endfunction

    initial begin
        // R8: outputs held at zero in reset even with live inputs
        a_i = 64'h1111_1111_1111_1111; b_i = 64'h2222_2222_2222_2222; cin_i = 1'b1;
        repeat (2) @(negedge clk);
        expect_eq("R8 reset sum", sum_o, '0);
        expect_eq("R8 reset cout", {{(W-1){1'b0}}, cout_o}, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i].a, VECS[i].b, VECS[i].cin);

        // R6: chains of nines ending in a generate, random position
        for (int i = 0; i < 20; i++) begin
            logic [W-1:0] a;
            int p;
            a = rand_bcd();
            p = $urandom_range(0, D - 2);
            for (int d = p + 1; d < D; d++) a[d*4 +: 4] = 4'h9;
            run_vec(a, to_bcd(longint'($urandom_range(1, 9))) << (p*4), 1'b0);
        end

        for (int i = 0; i < 60; i++) run_vec(rand_bcd(), rand_bcd(), 1'($urandom_range(0, 1)));

        // R8: latency, old result held until the next edge
        run_vec(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, 1'b0);
        @(negedge clk);
        a_i = 64'h0000_0000_0000_0005; b_i = 64'h0000_0000_0000_0005; cin_i = 1'b0;
        #1;
        expect_eq("R8 before edge", sum_o, 64'h3);
        @(negedge clk);
        expect_eq("R8 after edge", sum_o, 64'h10);

        // R8: reset mid-run clears outputs
        a_i = {D{4'h9}}; b_i = {D{4'h9}}; cin_i = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        expect_eq("R8 mid reset sum", sum_o, '0);
        expect_eq("R8 mid reset cout", {{(W-1){1'b0}}, cout_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule